// File: doc/BRIEF.md
# Secure Interrupt Router

The router collects up to 32 level interrupt sources into sticky pending bits and steers each one to four processors. Every source owns a 16-bit routing word holding, for each processor, a two-bit priority, a line-type bit that selects the IRQ or FIQ output, and a secure-ownership flag. For each processor the block drives an IRQ line, an FIQ line and a non-maskable indication. It also exports the index of the most urgent pending source that the processor can see.

Software reaches the block over a simple single-cycle register bus. Each access carries an address, write data, a write strobe and a secure attribute, and read data is returned combinationally. A non-secure access cannot see, clear or reconfigure state that belongs to a secure owner. The control register and each routing word can be written at three addresses: a plain write, a set alias and a clear alias. A lock bit protects the clock-gate and soft-reset bits against non-secure writes. The soft reset wipes the pending and routing state and then drops back to 0 by itself.

Top module: `sir_router`

## Requirements
- R1: After rst_ni is released, all outputs are 0, the control register (offset 0x0) reads 0 and the status register (offset 0x10) reads 0.
- R2: A source input that is high at a clock edge sets pending bit n, which is visible at bit n of the status register at 0x10. The bit stays set after the input returns low, until it is cleared.
- R3: Writing 1 to control bit 6 starts a soft reset. The bit reads 1 for exactly SRST_CYCLES cycles and then returns to 0 by itself. During that time all pending bits and routing words are held at 0.
- R4: Control bit 5 is the lock (1 = locked). While it is locked, non-secure writes leave bit 7 (clock gate) and bit 6 (soft reset) unchanged. A non-secure access can set the lock but cannot clear it.
- R5: A write to 0x14 clears pending bit n for each 1 in bit n of the data. A non-secure write does not clear a source that is secure-owned, which means some processor's secure flag is set for that source.
- R6: A non-secure read of 0x10 returns 0 for secure-owned sources. A secure read returns all pending bits.
- R7: The routing word of source n is at 0x20 + n*0x10 and reads back what was written. Processor k uses bits [4k+3:4k+2] for priority (0 masked, 1 low, 2 high, 3 non-maskable), bit 4k+1 for type (0 IRQ, 1 FIQ) and bit 4k for the secure flag.
- R8: For the control register and each routing word, a write to base+4 ORs the data into the register and a write to base+8 clears the bits that are 1 in the data.
- R9: A non-secure write to a routing word leaves the 4-bit field of processor k unchanged whenever that processor's secure flag is 1. The fields of the other processors are updated.
- R10: irq_o[k] is 1 when some pending source has nonzero priority and type 0 for processor k. fiq_o[k] is the same for type 1. A source with priority 0 drives neither line.
- R11: nmi_o[k] is 1 when some pending source has priority 3 for processor k.
- R12: top_idx_o[5k+4:5k] gives the pending source with the highest nonzero priority for processor k, and the lowest index wins a tie. top_valid_o[k] is 1 when such a source exists.
- R13: Control bit 7 is stored and driven on clk_gate_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt sources |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_secure_i | input | 1 | Access is secure |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | NUM_CPU | IRQ line per processor |
| fiq_o | output | NUM_CPU | FIQ line per processor |
| nmi_o | output | NUM_CPU | Non-maskable source pending per processor |
| top_idx_o | output | NUM_CPU*IDX_W | Most urgent pending source per processor |
| top_valid_o | output | NUM_CPU | top_idx_o field is meaningful |
| clk_gate_o | output | 1 | Stored clock-gate control bit |

## Verification
Some properties are checked on every cycle. A non-secure status read never shows a secure-owned bit. A non-secure clear never removes a secure-owned pending bit. A locked, non-secure control write neither moves the clock gate nor starts a soft reset. The soft reset never lasts longer than its cycle count and always leaves the pending bits empty, and an NMI indication always comes with an active line. Other behaviour shows only through the bench's scenarios: the alias arithmetic, which processor fields a non-secure write keeps, the exact soft-reset duration, and tie-breaking in the index selection. The bench checks these against a model that is updated one cycle at a time.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_WR,
    OP_SET,
    OP_CLR
  } wr_op_e;

  localparam logic [1:0] PRIO_MASKED = 2'd0;
  localparam logic [1:0] PRIO_NMI    = 2'd3;

  // low address nibble selects plain / set / clear alias
  function automatic wr_op_e decode_op(input logic [3:0] lo);
    case (lo)
      4'h0:    decode_op = OP_WR;
      4'h4:    decode_op = OP_SET;
      4'h8:    decode_op = OP_CLR;
      default: decode_op = OP_NONE;
    endcase
  endfunction

  function automatic logic [31:0] apply_op(input wr_op_e op, input logic [31:0] cur,
                                           input logic [31:0] wd);
    case (op)
      OP_WR:   apply_op = wd;
      OP_SET:  apply_op = cur | wd;
      OP_CLR:  apply_op = cur & ~wd;
      default: apply_op = cur;
    endcase
  endfunction

endpackage

// File: rtl/sir_ctrl.sv
module sir_ctrl
  import sir_pkg::*;
#(
  parameter int unsigned SRST_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  wr_op_e     op_i,
  input  logic [7:0] wdata_i,
  input  logic       secure_i,
  output logic       clk_gate_o,
  output logic       srst_o,
  output logic       lock_o
);

  logic             cg_q, srst_q, lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       cur, nv;
  logic             prot;

  assign cur  = {cg_q, srst_q, lock_q, 5'b0};
  assign nv   = 8'(apply_op(op_i, 32'(cur), 32'(wdata_i)));
  assign prot = lock_q && !secure_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cg_q   <= 1'b0;
      srst_q <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (srst_q) begin
        if (cnt_q == '0) srst_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (wr_en_i) begin
        if (!prot) begin
          cg_q <= nv[7];
          if (nv[6] && !srst_q) begin
            srst_q <= 1'b1;
            cnt_q  <= CNT_W'(SRST_CYCLES - 1);
          end
        end
        // non-secure may only raise the lock
        lock_q <= secure_i ? nv[5] : (lock_q | nv[5]);
      end
    end
  end

  assign clk_gate_o = cg_q;
  assign srst_o     = srst_q;
  assign lock_o     = lock_q;

endmodule

// File: rtl/sir_route_bank.sv
module sir_route_bank
  import sir_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CPU = 4,
  localparam int unsigned RT_W  = 4 * NUM_CPU,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  wr_op_e                         op_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [RT_W-1:0]                wdata_i,
  input  logic                           secure_i,
  input  logic                           srst_i,
  output logic [NUM_SRC-1:0][RT_W-1:0]   route_o,
  output logic [NUM_SRC-1:0]             owned_o
);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    logic              hit;
    logic [RT_W-1:0]   cand;
    logic [NUM_CPU-1:0] flags;

    assign hit  = wr_en_i && (idx_i == IDX_W'(n));
    assign cand = RT_W'(apply_op(op_i, 32'(route_o[n]), 32'(wdata_i)));

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
      logic [3:0] nib_q;
      logic       keep;

      assign keep = nib_q[0] && !secure_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          nib_q <= '0;
        else if (srst_i)      nib_q <= '0;
        else if (hit && !keep) nib_q <= cand[4*k +: 4];
      end

      assign route_o[n][4*k +: 4] = nib_q;
      assign flags[k]             = nib_q[0];
    end

    assign owned_o[n] = |flags;
  end

endmodule

// File: rtl/sir_pending.sv
module sir_pending #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  input  logic               srst_i,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q, kill;

  assign kill = clr_en_i ? clr_mask_i : '0;

  // a source held high re-asserts over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= '0;
    else if (srst_i) pend_q <= '0;
    else             pend_q <= (pend_q & ~kill) | src_i;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/sir_cpu_arb.sv
module sir_cpu_arb #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0][1:0]   prio_i,
  input  logic [NUM_SRC-1:0]        type_i,
  output logic                      irq_o,
  output logic                      fiq_o,
  output logic                      nmi_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic                      valid_o
);

  logic [1:0] best;

  always_comb begin
    irq_o = 1'b0;
    fiq_o = 1'b0;
    nmi_o = 1'b0;
    best  = 2'd0;
    idx_o = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (pend_i[n] && prio_i[n] != sir_pkg::PRIO_MASKED) begin
        if (type_i[n]) fiq_o = 1'b1;
        else           irq_o = 1'b1;
        if (prio_i[n] == sir_pkg::PRIO_NMI) nmi_o = 1'b1;
        // strict compare keeps the lowest index on ties
        if (prio_i[n] > best) begin
          best  = prio_i[n];
          idx_o = IDX_W'(n);
        end
      end
    end
    valid_o = (best != 2'd0);
  end

endmodule

// File: rtl/sir_router.sv
module sir_router
  import sir_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SRST_CYCLES = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned RT_W   = 4 * NUM_CPU,
  localparam int unsigned SLOT_W = ADDR_W - 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       src_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  input  logic                     bus_we_i,
  input  logic                     bus_secure_i,
  output logic [31:0]              bus_rdata_o,
  output logic [NUM_CPU-1:0]       irq_o,
  output logic [NUM_CPU-1:0]       fiq_o,
  output logic [NUM_CPU-1:0]       nmi_o,
  output logic [NUM_CPU*IDX_W-1:0] top_idx_o,
  output logic [NUM_CPU-1:0]       top_valid_o,
  output logic                     clk_gate_o
);

  wr_op_e                       op;
  logic [SLOT_W-1:0]            slot;
  logic                         ctrl_sel, stat_sel, clr_sel, route_sel;
  logic [IDX_W-1:0]             ridx;
  logic                         ctrl_we, route_we, clr_we;
  logic                         srst_q, lock_q;
  logic [NUM_SRC-1:0]           pend_q, sec_owned, vis, clr_mask;
  logic [NUM_SRC-1:0][RT_W-1:0] route_q;

  assign op        = decode_op(bus_addr_i[3:0]);
  assign slot      = bus_addr_i[ADDR_W-1:4];
  assign ctrl_sel  = (slot == '0);
  assign stat_sel  = (bus_addr_i == ADDR_W'(16));
  assign clr_sel   = (bus_addr_i == ADDR_W'(20));
  assign route_sel = (slot >= SLOT_W'(2)) && (slot < SLOT_W'(NUM_SRC + 2));
  assign ridx      = IDX_W'(slot - SLOT_W'(2));

  assign ctrl_we  = bus_we_i && ctrl_sel && (op != OP_NONE);
  assign route_we = bus_we_i && route_sel && (op != OP_NONE);
  assign clr_we   = bus_we_i && clr_sel;

  assign vis      = bus_secure_i ? '1 : ~sec_owned;
  assign clr_mask = bus_wdata_i[NUM_SRC-1:0] & vis;

  sir_ctrl #(
    .SRST_CYCLES(SRST_CYCLES)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ctrl_we),
    .op_i       (op),
    .wdata_i    (bus_wdata_i[7:0]),
    .secure_i   (bus_secure_i),
    .clk_gate_o (clk_gate_o),
    .srst_o     (srst_q),
    .lock_o     (lock_q)
  );

  sir_route_bank #(
    .NUM_SRC(NUM_SRC),
    .NUM_CPU(NUM_CPU)
  ) i_routes (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (route_we),
    .op_i     (op),
    .idx_i    (ridx),
    .wdata_i  (bus_wdata_i[RT_W-1:0]),
    .secure_i (bus_secure_i),
    .srst_i   (srst_q),
    .route_o  (route_q),
    .owned_o  (sec_owned)
  );

  sir_pending #(
    .NUM_SRC(NUM_SRC)
  ) i_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .clr_en_i   (clr_we),
    .clr_mask_i (clr_mask),
    .srst_i     (srst_q),
    .pend_o     (pend_q)
  );

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    logic [NUM_SRC-1:0][1:0] prio;
    logic [NUM_SRC-1:0]      kind;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_unpack
      assign prio[n] = route_q[n][4*k+2 +: 2];
      assign kind[n] = route_q[n][4*k+1];
    end

    sir_cpu_arb #(
      .NUM_SRC(NUM_SRC)
    ) i_arb (
      .pend_i  (pend_q),
      .prio_i  (prio),
      .type_i  (kind),
      .irq_o   (irq_o[k]),
      .fiq_o   (fiq_o[k]),
      .nmi_o   (nmi_o[k]),
      .idx_o   (top_idx_o[k*IDX_W +: IDX_W]),
      .valid_o (top_valid_o[k])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (ctrl_sel && bus_addr_i[3:0] == 4'h0)
      bus_rdata_o = {24'b0, clk_gate_o, srst_q, lock_q, 5'b0};
    else if (stat_sel)
      bus_rdata_o = 32'(pend_q & vis);
    else if (route_sel && bus_addr_i[3:0] == 4'h0)
      bus_rdata_o = 32'(route_q[ridx]);
  end

endmodule

// File: rtl/sir_router_chk.sv
module sir_router_chk #(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SRST_CYCLES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic               bus_we_i,
  input logic               bus_secure_i,
  input logic [31:0]        bus_rdata_o,
  input logic [NUM_CPU-1:0] irq_o,
  input logic [NUM_CPU-1:0] fiq_o,
  input logic [NUM_CPU-1:0] nmi_o,
  input logic               clk_gate_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] owned_i,
  input logic               lock_i,
  input logic               srst_i
);

  localparam int unsigned RUN_W = $clog2(SRST_CYCLES + 2);

  logic [RUN_W-1:0] run_q;
  logic             ns_ctrl_wr, ns_clr_wr;

  assign ns_ctrl_wr = bus_we_i && !bus_secure_i && (bus_addr_i[ADDR_W-1:4] == '0);
  assign ns_clr_wr  = bus_we_i && !bus_secure_i && (bus_addr_i == ADDR_W'(20));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  run_q <= '0;
    else if (!srst_i)                             run_q <= '0;
    else if (run_q != RUN_W'(SRST_CYCLES + 1))    run_q <= run_q + 1'b1;
  end

  AST_LOCK_KEEPS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_ctrl_wr && lock_i) |=> $stable(clk_gate_o)); // R4

  AST_LOCK_BLOCKS_SRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_ctrl_wr && lock_i) |=> !$rose(srst_i)); // R4

  AST_NS_STATUS_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_secure_i && bus_addr_i == ADDR_W'(16)) |->
      ((bus_rdata_o[NUM_SRC-1:0] & owned_i) == '0)); // R6

  AST_NS_CLEAR_SPARES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_clr_wr && !srst_i) |=>
      ((pend_i & $past(pend_i & owned_i)) == $past(pend_i & owned_i))); // R5

  AST_SRST_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |-> (run_q < RUN_W'(SRST_CYCLES))); // R3

  AST_SRST_LEAVES_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(srst_i) |-> (pend_i == '0)); // R3

  AST_LINE_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o | fiq_o) != '0) |-> (pend_i != '0)); // R10

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_nmi
    AST_NMI_HAS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_o[k] |-> (irq_o[k] || fiq_o[k])); // R11
  end

endmodule

bind sir_router sir_router_chk #(
  .NUM_SRC     (NUM_SRC),
  .NUM_CPU     (NUM_CPU),
  .ADDR_W      (ADDR_W),
  .SRST_CYCLES (SRST_CYCLES)
) i_sir_router_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_secure_i (bus_secure_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .nmi_o        (nmi_o),
  .clk_gate_o   (clk_gate_o),
  .pend_i       (pend_q),
  .owned_i      (sec_owned),
  .lock_i       (lock_q),
  .srst_i       (srst_q)
);

// File: tb/test_sir_router.sv
`timescale 1ns/1ps
module test_sir_router;

  localparam int NSRC = 32;
  localparam int NCPU = 4;
  localparam int SRST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        secure = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq, fiq, nmi, tvalid;
  logic [19:0] tidx;
  logic        cg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_route [NSRC];
  logic [31:0] m_pend = '0;
  logic        m_cg = 1'b0, m_lock = 1'b0, m_srst = 1'b0;
  int          m_cnt = 0;
  logic [31:0] rd, rd_exp;

  always #4 clk = ~clk;

  sir_router i_sir_router (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_secure_i(secure), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .nmi_o(nmi), .top_idx_o(tidx), .top_valid_o(tvalid), .clk_gate_o(cg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] owned_vec();
    logic [31:0] o = '0;
    for (int n = 0; n < NSRC; n++)
      for (int k = 0; k < NCPU; k++) if (m_route[n][4*k]) o[n] = 1'b1;
    return o;
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic s);
    int slot = int'(a[11:4]);
    if (a == 12'h000) return {24'b0, m_cg, m_srst, m_lock, 5'b0};
    if (a == 12'h010) return m_pend & (s ? 32'hFFFF_FFFF : ~owned_vec());
    if (slot >= 2 && slot < NSRC + 2 && a[3:0] == 4'h0) return {16'b0, m_route[slot-2]};
    return '0;
  endfunction

  function automatic logic [31:0] op_apply(input logic [3:0] lo, input logic [31:0] c,
                                           input logic [31:0] d);
    if (lo == 4'h0) return d;
    if (lo == 4'h4) return c | d;
    return c & ~d;
  endfunction

  task automatic model_step(input logic [31:0] s, input logic w, input logic [11:0] a,
                            input logic [31:0] d, input logic sc);
    logic        old_srst = m_srst;
    logic        old_lock = m_lock;
    logic [31:0] own = owned_vec();
    bit          opok = (a[3:0] == 4'h0) || (a[3:0] == 4'h4) || (a[3:0] == 4'h8);
    int          slot = int'(a[11:4]);
    if (old_srst) begin
      if (m_cnt == 0) m_srst = 1'b0;
      else m_cnt--;
    end
    if (w && a[11:4] == 8'h0 && opok) begin
      logic [7:0] nv = 8'(op_apply(a[3:0], {24'b0, m_cg, old_srst, old_lock, 5'b0}, d));
      if (!(old_lock && !sc)) begin
        m_cg = nv[7];
        if (nv[6] && !old_srst) begin m_srst = 1'b1; m_cnt = SRST - 1; end
      end
      m_lock = sc ? nv[5] : (old_lock | nv[5]);
    end
    if (old_srst) begin
      m_pend = '0;
      for (int n = 0; n < NSRC; n++) m_route[n] = '0;
    end else begin
      logic [31:0] kill = '0;
      if (w && a == 12'h014) kill = d & (sc ? 32'hFFFF_FFFF : ~own);
      if (w && slot >= 2 && slot < NSRC + 2 && opok) begin
        logic [15:0] old = m_route[slot-2];
        logic [15:0] nv2 = 16'(op_apply(a[3:0], {16'b0, old}, d));
        for (int k = 0; k < NCPU; k++)
          if (!(old[4*k] && !sc)) m_route[slot-2][4*k +: 4] = nv2[4*k +: 4];
      end
      m_pend = (m_pend & ~kill) | s;
    end
  endtask

  task automatic cyc(input logic [31:0] s, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic sc);
    @(negedge clk);
    src = s; we = w; addr = a; wdata = d; secure = sc;
    #2;
    rd     = rdata;
    rd_exp = model_read(a, sc);
    model_step(s, w, a, d, sc);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(); cyc('0, 1'b0, 12'h000, '0, 1'b0); endtask

  task automatic compare_outputs(input string tag);
    for (int k = 0; k < NCPU; k++) begin
      logic       ei = 1'b0, ef = 1'b0, en = 1'b0;
      logic [1:0] best = 2'd0;
      logic [4:0] bi = '0;
      for (int n = 0; n < NSRC; n++) begin
        logic [1:0] p = m_route[n][4*k+2 +: 2];
        if (m_pend[n] && p != 2'd0) begin
          if (m_route[n][4*k+1]) ef = 1'b1; else ei = 1'b1;
          if (p == 2'd3) en = 1'b1;
          if (p > best) begin best = p; bi = 5'(n); end
        end
      end
      check({tag, " R10 irq"}, 32'(irq[k]), 32'(ei));
      check({tag, " R10 fiq"}, 32'(fiq[k]), 32'(ef));
      check({tag, " R11 nmi"}, 32'(nmi[k]), 32'(en));
      check({tag, " R12 valid"}, 32'(tvalid[k]), 32'(best != 2'd0));
      if (best != 2'd0) check({tag, " R12 idx"}, 32'(tidx[5*k +: 5]), 32'(bi));
    end
    check({tag, " R13 gate"}, 32'(cg), 32'(m_cg));
  endtask

  function automatic logic [11:0] raddr(input int n);
    return 12'(32 + n * 16);
  endfunction

  initial begin
    for (int n = 0; n < NSRC; n++) m_route[n] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle();
    check("R1 outputs", {irq, fiq, nmi, tvalid, 15'b0, cg}, '0);
    cyc('0, 1'b0, 12'h000, '0, 1'b1); check("R1 ctrl", rd, 32'h0);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R1 status", rd, 32'h0);

    // R7/R2/R10 basic routing
    cyc('0, 1'b1, raddr(5), 32'h0004, 1'b0);
    cyc(32'h20, 1'b0, raddr(5), '0, 1'b0); check("R7 readback", rd, 32'h0004);
    check("R10 irq src5", 32'(irq), 32'h1);
    check("R10 fiq idle", 32'(fiq), 32'h0);
    cyc('0, 1'b0, 12'h010, '0, 1'b0); check("R2 status sticky", rd, 32'h20);
    cyc('0, 1'b1, raddr(9), 32'h00A0, 1'b0);
    cyc(32'h200, 1'b0, 12'h000, '0, 1'b0);
    check("R10 fiq cpu1", 32'(fiq), 32'h2);
    cyc('0, 1'b1, raddr(10), 32'h0002, 1'b0);
    cyc(32'h400, 1'b0, 12'h000, '0, 1'b0);
    check("R10 masked prio", 32'(fiq[0]), 32'h0);
    compare_outputs("dir1");

    // R12 tie-break, R11 nmi
    cyc('0, 1'b1, raddr(3), 32'h0008, 1'b0);
    cyc('0, 1'b1, raddr(12), 32'h0008, 1'b0);
    cyc(32'h1008, 1'b0, 12'h000, '0, 1'b0);
    check("R12 tie lowest", 32'(tidx[4:0]), 32'd3);
    cyc('0, 1'b1, raddr(20), 32'h000C, 1'b0);
    cyc(32'h0010_0000, 1'b0, 12'h000, '0, 1'b0);
    check("R11 nmi cpu0", 32'(nmi), 32'h1);
    check("R12 nmi wins", 32'(tidx[4:0]), 32'd20);
    compare_outputs("dir2");

    // R5 secure clear all
    cyc('0, 1'b1, 12'h014, 32'hFFFF_FFFF, 1'b1);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R5 cleared", rd, 32'h0);
    check("R10 lines drop", 32'({irq, fiq}), 32'h0);

    // R8 aliases
    cyc('0, 1'b1, raddr(5) + 12'h4, 32'h0020, 1'b0);
    cyc('0, 1'b0, raddr(5), '0, 1'b0); check("R8 route set", rd, 32'h0024);
    cyc('0, 1'b1, raddr(5) + 12'h8, 32'h0004, 1'b0);
    cyc('0, 1'b0, raddr(5), '0, 1'b0); check("R8 route clr", rd, 32'h0020);
    cyc('0, 1'b1, 12'h004, 32'h80, 1'b0);
    check("R13 gate set alias", 32'(cg), 32'h1);
    cyc('0, 1'b1, 12'h008, 32'h80, 1'b0);
    check("R8 gate clr alias", 32'(cg), 32'h0);

    // R6/R5/R9 secure ownership
    cyc('0, 1'b1, raddr(7), 32'h0500, 1'b1);
    cyc(32'h80, 1'b0, 12'h000, '0, 1'b0);
    cyc('0, 1'b0, 12'h010, '0, 1'b0); check("R6 ns hides", rd & 32'h80, 32'h0);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R6 sec sees", rd & 32'h80, 32'h80);
    cyc('0, 1'b1, 12'h014, 32'h80, 1'b0);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R5 ns spares", rd & 32'h80, 32'h80);
    cyc('0, 1'b1, raddr(7), 32'h0000, 1'b0);
    cyc('0, 1'b0, raddr(7), '0, 1'b0); check("R9 keep secure nib", rd, 32'h0500);
    cyc('0, 1'b1, raddr(7), 32'h000C, 1'b0);
    cyc('0, 1'b0, raddr(7), '0, 1'b0); check("R9 other nib moves", rd, 32'h050C);
    check("R10 cpu2 line", 32'(irq[2]), 32'h1);
    compare_outputs("dir3");
    cyc('0, 1'b1, 12'h014, 32'h80, 1'b1);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R5 sec clears", rd & 32'h80, 32'h0);

    // R4 lock
    cyc('0, 1'b1, 12'h000, 32'h20, 1'b1);
    cyc('0, 1'b1, 12'h000, 32'hE0, 1'b0);
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R4 ns blocked", rd, 32'h20);
    check("R4 gate held", 32'(cg), 32'h0);
    cyc('0, 1'b1, 12'h008, 32'h20, 1'b0);
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R4 ns cannot unlock", rd, 32'h20);
    cyc('0, 1'b1, 12'h000, 32'h80, 1'b1);
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R4 sec unlock", rd, 32'h80);
    cyc('0, 1'b1, 12'h008, 32'h80, 1'b1);

    // R3 soft reset
    cyc(32'h28, 1'b0, 12'h000, '0, 1'b0);
    cyc('0, 1'b1, 12'h000, 32'h40, 1'b0);
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R3 bit set", rd, 32'h40);
    idle(); idle();
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R3 last cycle", rd, 32'h40);
    cyc('0, 1'b0, 12'h000, '0, 1'b0); check("R3 self clear", rd, 32'h0);
    cyc('0, 1'b0, 12'h010, '0, 1'b1); check("R3 pend wiped", rd, 32'h0);
    cyc('0, 1'b0, raddr(3), '0, 1'b1); check("R3 route wiped", rd, 32'h0);
    compare_outputs("srst");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 5;
      logic [31:0] s = ($urandom % 3 == 0) ? ($urandom & 32'hFF) : '0;
      logic sc = 1'($urandom);
      if (r < 2) begin
        logic [11:0] off = 12'(4 * ($urandom % 3));
        cyc(s, 1'b1, raddr($urandom % 8) + off, $urandom & 32'hFFFF, sc);
      end else if (r == 2) begin
        cyc(s, 1'b1, 12'h014, $urandom & 32'hFF, sc);
      end else if (r == 3) begin
        cyc(s, 1'b0, 12'h010, '0, sc);
        check("R6 rand status", rd, rd_exp);
      end else begin
        cyc(s, 1'b0, raddr($urandom % 8), '0, sc);
        check("R9 rand route", rd, rd_exp);
      end
      compare_outputs("rand");
    end

    idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=0x0 exp=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule